// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides its input clock by an even ratio N = 2 × (32 × B + A). It uses a swallow count A (0 to 31) and a main count B (3 to 4095). A fixed halving stage feeds a behavioural dual-modulus prescaler. The prescaler divides by 33 while the swallow count is still nonzero, and by 32 after that. Each prescaler cycle takes one step off the main count. When the main count runs out, both counts reload and the block emits one output pulse that lasts a single clock. A ratio of 192 is the smallest the counters accept, and the largest is 262142.

A loader supplies A and B with a one-cycle load strobe. Values that pass the check are held in a staging register. The counters pick up the staged values only at the next full reload, so a period that is already running always finishes with its old ratio. A load with B below A, or with B below 3, raises an error pulse and leaves the staged values unchanged. A standby input holds the whole counter chain in its reload state and keeps the output low. The same block, with A held at zero, can serve as a reference-divider path.

Top module: `swallow_divider`

## Requirements
- R1: With a valid swallow value A and main value B in force, consecutive rising edges of `div_pulse` are exactly 2 × (32 × B + A) clock cycles apart.
- R2: `div_pulse` is high for exactly one clock cycle per division period.
- R3: Every division period is an even number of clock cycles; for A = 8 and B = 566 the period is 36240 cycles.
- R4: For the first A prescaler cycles of a period the prescaler spans 66 clocks, and for the remaining B − A it spans 64 clocks; with A = B every prescaler cycle spans 66 clocks, so the period is 66 × B.
- R5: A load accepted in the middle of a period does not change that period; the new ratio applies from the period that starts at the next output pulse.
- R6: A load strobe with `main_in` < `swallow_in` or `main_in` < 3 makes `cfg_err` high for exactly the one cycle after the strobe, and the ratio in force, and the one that follows it, stay the previous one.
- R7: A load strobe with valid values leaves `cfg_err` low.
- R8: While `standby` is high, `div_pulse` stays low. After `standby` falls, the first pulse arrives exactly N cycles later, where N is the ratio of the staged values.
- R9: During reset `div_pulse` and `cfg_err` are low. After reset the staged values are A = 0 and B = 3, so the first pulse comes 192 cycles after release and repeats every 192 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hold counters in reload and force the output low |
| ld_valid | input | 1 | One-cycle strobe that offers new A and B values |
| swallow_in | input | 5 | Swallow value A offered with the strobe |
| main_in | input | 12 | Main value B offered with the strobe |
| cfg_err | output | 1 | One-cycle pulse after a rejected load |
| div_pulse | output | 1 | One-cycle pulse per division period |

## Verification
The output pulse is registered from the terminal count, so it rises on the same edge on which the counters reload. The bench therefore samples on the falling edge and measures each period as the number of falling edges from one pulse to the next. Loads are issued on the falling edge where a pulse is seen. That keeps every load at least 190 cycles away from the next reload, and so the period that contains the load must still show the old ratio. `cfg_err` is registered from the strobe and is checked on the very next falling edge, and low on the one after. After a reset or standby release on a falling edge, the first pulse is expected on the N-th falling edge.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   typedef enum logic [1:0] {
      CFG_GOOD     = 2'd0,
      CFG_SWL_HIGH = 2'd1,
      CFG_MAIN_LOW = 2'd2
   } cfg_verdict_e;

   function automatic cfg_verdict_e judge_cfg(input int unsigned swl,
                                              input int unsigned mainv,
                                              input int unsigned min_main);
      if (mainv < min_main)
         return CFG_MAIN_LOW;
      else if (mainv < swl)
         return CFG_SWL_HIGH;
      else
         return CFG_GOOD;
   endfunction

endpackage

// File: rtl/swdiv_cfg_guard.sv
module swdiv_cfg_guard
   import swdiv_pkg::*;
#(
   parameter int unsigned SWL_W    = 5,
   parameter int unsigned MAIN_W   = 12,
   parameter int unsigned MIN_MAIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [SWL_W-1:0]  swl_in,
   input  logic [MAIN_W-1:0] main_in,
   output logic [SWL_W-1:0]  swl_hold,
   output logic [MAIN_W-1:0] main_hold,
   output logic              reject
);

   cfg_verdict_e verdict;

   always_comb begin
      verdict = judge_cfg(int'(swl_in), int'(main_in), MIN_MAIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swl_hold  <= '0;
         main_hold <= MAIN_W'(MIN_MAIN);
         reject    <= 1'b0;
      end else begin
         reject <= ld_valid && (verdict != CFG_GOOD);
         if (ld_valid && (verdict == CFG_GOOD)) begin
            swl_hold  <= swl_in;
            main_hold <= main_in;
         end
      end
   end

   a_r6_reject_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> ($stable(swl_hold) && $stable(main_hold)));

   a_r6_hold_always_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (main_hold >= MAIN_W'(MIN_MAIN)) && (main_hold >= MAIN_W'(swl_hold)));

   a_r6_reject_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> $past(ld_valid));

endmodule

// File: rtl/swdiv_halver.sv
module swdiv_halver #(
   parameter bit HALVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (HALVE) begin : g_half
         logic phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase <= 1'b0;
            else if (clr)
               phase <= 1'b0;
            else
               phase <= ~phase;
         end
         assign tick = phase;

         a_r3_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !clr) |=> !tick);
      end else begin : g_pass
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
   parameter int unsigned PRE_LOG2 = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic wide,
   output logic wrap
);

   localparam int unsigned CNT_W    = PRE_LOG2 + 1;
   localparam int unsigned BASE_MOD = 2 ** PRE_LOG2;

   logic [CNT_W-1:0] pre_cnt;
   logic [CNT_W-1:0] top_idx;

   always_comb begin
      top_idx = wide ? CNT_W'(BASE_MOD) : CNT_W'(BASE_MOD - 1);
      wrap    = tick && (pre_cnt == top_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_cnt <= '0;
      else if (clr || wrap)
         pre_cnt <= '0;
      else if (tick)
         pre_cnt <= pre_cnt + CNT_W'(1);
   end

   a_r4_narrow_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> (pre_cnt < CNT_W'(BASE_MOD)));

   a_r4_wide_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= CNT_W'(BASE_MOD));

   a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_cnt == '0));

endmodule

// File: rtl/swdiv_count_ctrl.sv
module swdiv_count_ctrl #(
   parameter int unsigned SWL_W    = 5,
   parameter int unsigned MAIN_W   = 12,
   parameter int unsigned MIN_MAIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              wrap,
   input  logic [SWL_W-1:0]  swl_hold,
   input  logic [MAIN_W-1:0] main_hold,
   output logic              wide,
   output logic              last,
   output logic              reload
);

   logic [SWL_W-1:0]  swl_cnt;
   logic [MAIN_W-1:0] main_cnt;

   always_comb begin
      wide   = (swl_cnt != '0);
      last   = wrap && (main_cnt == MAIN_W'(1));
      reload = standby || last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swl_cnt  <= '0;
         main_cnt <= MAIN_W'(MIN_MAIN);
      end else if (reload) begin
         swl_cnt  <= swl_hold;
         main_cnt <= main_hold;
      end else if (wrap) begin
         main_cnt <= main_cnt - MAIN_W'(1);
         if (swl_cnt != '0)
            swl_cnt <= swl_cnt - SWL_W'(1);
      end
   end

   a_r4_swallow_within_main: assert property (@(posedge clk) disable iff (!rst_n)
      MAIN_W'(swl_cnt) <= main_cnt);

   a_r1_main_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      main_cnt != '0);

   a_r5_counts_hold_without_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !wrap) |=> ($stable(swl_cnt) && $stable(main_cnt)));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int unsigned SWL_W    = 5,
   parameter int unsigned MAIN_W   = 12,
   parameter int unsigned PRE_LOG2 = 5,
   parameter int unsigned MIN_MAIN = 3,
   parameter bit          HALVE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              ld_valid,
   input  logic [SWL_W-1:0]  swallow_in,
   input  logic [MAIN_W-1:0] main_in,
   output logic              cfg_err,
   output logic              div_pulse
);

   generate
      if (SWL_W > PRE_LOG2) begin : g_bad_swl
         $error("swallow width exceeds prescaler resolution");
      end
      if (SWL_W > MAIN_W) begin : g_bad_main
         $error("main width narrower than swallow width");
      end
      if ((MIN_MAIN < 1) || (MIN_MAIN >= 2 ** MAIN_W)) begin : g_bad_min
         $error("minimum main value out of range");
      end
   endgenerate

   logic [SWL_W-1:0]  swl_hold;
   logic [MAIN_W-1:0] main_hold;
   logic              tick;
   logic              wide;
   logic              wrap;
   logic              last;
   logic              reload;

   swdiv_cfg_guard #(
      .SWL_W   (SWL_W),
      .MAIN_W  (MAIN_W),
      .MIN_MAIN(MIN_MAIN)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_valid),
      .swl_in   (swallow_in),
      .main_in  (main_in),
      .swl_hold (swl_hold),
      .main_hold(main_hold),
      .reject   (cfg_err)
   );

   swdiv_halver #(
      .HALVE(HALVE)
   ) u_half (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (reload),
      .tick (tick)
   );

   swdiv_prescaler #(
      .PRE_LOG2(PRE_LOG2)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (reload),
      .tick (tick),
      .wide (wide),
      .wrap (wrap)
   );

   swdiv_count_ctrl #(
      .SWL_W   (SWL_W),
      .MAIN_W  (MAIN_W),
      .MIN_MAIN(MIN_MAIN)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby  (standby),
      .wrap     (wrap),
      .swl_hold (swl_hold),
      .main_hold(main_hold),
      .wide     (wide),
      .last     (last),
      .reload   (reload)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_pulse <= 1'b0;
      else
         div_pulse <= last && !standby;
   end

   a_r2_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   a_r8_standby_silences: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !div_pulse);

endmodule

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        ld_valid = 1'b0;
   logic [4:0]  swallow_in = '0;
   logic [11:0] main_in = '0;
   logic        cfg_err;
   logic        div_pulse;

   int checks = 0;
   int errors = 0;
   int cur_n = 192;
   bit done = 1'b0;

   always #10 clk = ~clk;

   swallow_divider u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby   (standby),
      .ld_valid  (ld_valid),
      .swallow_in(swallow_in),
      .main_in   (main_in),
      .cfg_err   (cfg_err),
      .div_pulse (div_pulse)
   );

   function automatic int ratio(input int a, input int b);
      return 2 * (32 * b + a);
   endfunction

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic count_to_pulse(input int start, output int n);
      n = start;
      do begin
         @(negedge clk);
         n++;
      end while (!div_pulse && n < 300000);
   endtask

   task automatic wait_pulse();
      int guard_n;
      count_to_pulse(0, guard_n);
   endtask

   // Called on the falling edge where a pulse is seen.
   task automatic load_and_follow(input int a, input int b, input bit valid);
      int n;
      ld_valid   = 1'b1;
      swallow_in = 5'(a);
      main_in    = 12'(b);
      @(negedge clk);
      ld_valid = 1'b0;
      if (valid) check("R7 cfg_err after valid load", int'(cfg_err), 0);
      else       check("R6 cfg_err after rejected load", int'(cfg_err), 1);
      @(negedge clk);
      check("R6 cfg_err one cycle only", int'(cfg_err), 0);
      count_to_pulse(2, n);
      check("R5 period holding the load keeps old ratio", n, cur_n);
      @(negedge clk);
      check("R2 pulse width one cycle", int'(div_pulse), 0);
      count_to_pulse(1, n);
      if (valid) begin
         cur_n = ratio(a, b);
         if (a == b) check("R4 all-wide period 66*B", n, 66 * b);
         else        check("R1 period matches ratio", n, cur_n);
         check("R3 period even", n % 2, 0);
      end else begin
         check("R6 rejected load leaves ratio", n, cur_n);
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check("R9 div_pulse low in reset", int'(div_pulse), 0);
      check("R9 cfg_err low in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      count_to_pulse(0, n);
      check("R9 first pulse after reset", n, 192);
      count_to_pulse(0, n);
      check("R9 default period", n, 192);

      for (int b = 3; b <= 6; b++) begin
         for (int a = 0; a <= b; a++) begin
            load_and_follow(a, b, 1'b1);
         end
      end
      load_and_follow(31, 31, 1'b1);
      load_and_follow(0, 100, 1'b1);
      load_and_follow(31, 100, 1'b1);
      load_and_follow(17, 40, 1'b1);

      load_and_follow(0, 2, 1'b0);
      load_and_follow(7, 6, 1'b0);
      load_and_follow(31, 30, 1'b0);

      standby = 1'b1;
      n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (div_pulse) n++;
      end
      check("R8 no pulses in standby", n, 0);
      standby = 1'b0;
      count_to_pulse(0, n);
      check("R8 first pulse after standby", n, cur_n);

      load_and_follow(8, 566, 1'b1);
      check("R3 worked example ratio", cur_n, 36240);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule